// File: doc/BRIEF.md
# Frame-Slip Elastic Store

This block sits between a receive path timed by a recovered line clock and a transmit path timed by the local master clock. Framed TDM words enter on the write clock with a start-of-frame marker. They leave on the read clock as a continuous word stream with its own start-of-frame marker. The two clocks are never assumed to be equal. The store absorbs small phase differences. When the long-term rates differ, it deletes or repeats one whole frame at a time. A slip therefore never splits a frame and never shifts a time slot.

Storage holds two frames. The write and read sides exchange only 2-bit frame counters, Gray coded and passed through two-flop synchronizers. Each side compares the counters only at its own frame start. If the reader reaches the end of a frame and no newer complete frame is available, it plays the same frame again and raises an underflow pulse. If the writer sees a new frame begin while the slot it would fill still holds the frame being read, it discards the whole incoming frame and raises an overflow pulse. Both pulses appear in the read clock domain, and each direction has its own wrapping event counter.

Top module: `slip_frame_buffer`

## Requirements
- R1: While rst_ni is low and after its release, rd_valid_o, rd_sof_o, slip_under_o and slip_over_o are low and both event counters read zero.
- R2: The output stays idle until one complete frame of FRAME_LEN words has been written. After that, rd_valid_o stays high and one word is delivered on every read clock. rd_sof_o marks every FRAME_LEN-th word.
- R3: Every output frame is one intact written frame: the word at position k is the k-th word written for that frame, for k from 0 to FRAME_LEN-1.
- R4: If no newer complete frame is available at a read frame start, the frame just read is played again. slip_under_o pulses for one cycle in the same cycle as rd_sof_o of the repeated frame.
- R5: A frame whose start arrives while both slots are occupied (one of them still being read) is discarded as a whole. slip_over_o pulses once, in the read clock domain.
- R6: under_cnt_o and over_cnt_o increment by one on each pulse of slip_under_o and slip_over_o respectively, and wrap modulo 2^CNT_W.
- R7: Words with wr_valid_i high that do not belong to an accepted frame (before any wr_sof_i, or after a discarded start) are not stored. A frame cut short by a new wr_sof_i is never delivered.
- R8: Frames leave in write order. Excluding repeats, every written frame either appears exactly once or is counted in over_cnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered line clock (write side) |
| rd_clk_i | input | 1 | Local master clock (read side) |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_valid_i | input | 1 | Write word strobe |
| wr_sof_i | input | 1 | Marks the first word of a written frame |
| wr_data_i | input | DATA_W | Write word |
| rd_valid_o | output | 1 | Output word valid, high once output has started |
| rd_sof_o | output | 1 | Marks the first word of an output frame |
| rd_data_o | output | DATA_W | Output word |
| slip_under_o | output | 1 | One-cycle pulse: frame repeated |
| slip_over_o | output | 1 | One-cycle pulse: incoming frame discarded |
| under_cnt_o | output | CNT_W | Count of repeat slips, wrapping |
| over_cnt_o | output | CNT_W | Count of discard slips, wrapping |

## Verification
Some properties hold on every read cycle, and the assertions check these: output continuity once started, start-of-frame spacing of exactly FRAME_LEN words, repeat pulses only on a start-of-frame, and each counter stepping by one exactly when its pulse is high. Other behaviour only shows across whole runs, so the bench scenarios cover it. Frame integrity, ordering, and the rule that every written frame is either delivered or counted as discarded all depend on the write and read rates, so the bench drives slow, fast, equal and gapped writers and checks these. The bench also covers stray and aborted write words, the idle period before the first full frame, and counter wrap.

// File: rtl/slip_pkg.sv
`timescale 1ns/1ps
package slip_pkg;
  localparam int unsigned IDX_W = 2;
  typedef logic [IDX_W-1:0] fidx_t;

  function automatic fidx_t to_gray(fidx_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic fidx_t from_gray(fidx_t g);
    fidx_t b;
    b[IDX_W-1] = g[IDX_W-1];
    for (int i = IDX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/slip_sync.sv
`timescale 1ns/1ps
module slip_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/slip_wr_ctrl.sv
`timescale 1ns/1ps
module slip_wr_ctrl
  import slip_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 8,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  fidx_t             rd_gray_i,
  output fidx_t             wr_gray_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              drop_tgl_o
);
  localparam int unsigned POS_W = ADDR_W - 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  fidx_t            wr_idx_q;
  fidx_t            rd_idx;
  logic             active_q;
  logic [POS_W-1:0] pos_q;
  logic             full;

  assign rd_idx  = from_gray(rd_gray_i);
  // slot of frame wr_idx-2 still holds the frame being read
  assign full    = fidx_t'(wr_idx_q - rd_idx) == fidx_t'(2);
  assign we_o    = valid_i & (sof_i ? ~full : active_q);
  assign waddr_o = {wr_idx_q[0], (sof_i ? '0 : pos_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q   <= '0;
      wr_gray_o  <= '0;
      active_q   <= 1'b0;
      pos_q      <= '0;
      drop_tgl_o <= 1'b0;
    end else if (valid_i) begin
      if (sof_i) begin
        if (full) begin
          active_q   <= 1'b0;
          drop_tgl_o <= ~drop_tgl_o;
        end else begin
          active_q <= 1'b1;
          pos_q    <= POS_W'(1);
        end
      end else if (active_q) begin
        if (pos_q == LAST_POS) begin
          active_q  <= 1'b0;
          pos_q     <= '0;
          wr_idx_q  <= wr_idx_q + fidx_t'(1);
          wr_gray_o <= to_gray(wr_idx_q + fidx_t'(1));
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/slip_rd_ctrl.sv
`timescale 1ns/1ps
module slip_rd_ctrl
  import slip_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fidx_t             wr_gray_i,
  input  logic              drop_tgl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output fidx_t             rd_gray_o,
  output logic              valid_o,
  output logic              sof_o,
  output logic [DATA_W-1:0] data_o,
  output logic              under_o,
  output logic              over_o,
  output logic [CNT_W-1:0]  under_cnt_o,
  output logic [CNT_W-1:0]  over_cnt_o
);
  localparam int unsigned POS_W = ADDR_W - 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  fidx_t            rd_idx_q, wr_idx, sel_idx;
  logic             started_q, first_q, drop_seen_q;
  logic [POS_W-1:0] pos_q;
  logic             at_start, avail, advance, uf, ov;

  assign wr_idx   = from_gray(wr_gray_i);
  assign avail    = fidx_t'(wr_idx - rd_idx_q) == fidx_t'(2);
  assign at_start = started_q & (pos_q == '0);
  assign advance  = at_start & ~first_q & avail;
  assign uf       = at_start & ~first_q & ~avail;
  assign sel_idx  = advance ? rd_idx_q + fidx_t'(1) : rd_idx_q;
  assign raddr_o  = {sel_idx[0], pos_q};
  assign ov       = drop_tgl_i ^ drop_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q   <= 1'b0;
      first_q     <= 1'b0;
      pos_q       <= '0;
      rd_idx_q    <= '0;
      rd_gray_o   <= '0;
      valid_o     <= 1'b0;
      sof_o       <= 1'b0;
      data_o      <= '0;
      under_o     <= 1'b0;
      under_cnt_o <= '0;
      drop_seen_q <= 1'b0;
      over_o      <= 1'b0;
      over_cnt_o  <= '0;
    end else begin
      drop_seen_q <= drop_tgl_i;
      over_o      <= ov;
      over_cnt_o  <= over_cnt_o + CNT_W'(ov);
      under_o     <= uf;
      under_cnt_o <= under_cnt_o + CNT_W'(uf);
      if (!started_q) begin
        if (wr_idx != '0) begin
          started_q <= 1'b1;
          first_q   <= 1'b1;
        end
      end else begin
        valid_o <= 1'b1;
        sof_o   <= at_start;
        data_o  <= rdata_i;
        pos_q   <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
        if (at_start) begin
          first_q   <= 1'b0;
          rd_idx_q  <= sel_idx;
          rd_gray_o <= to_gray(sel_idx);
        end
      end
    end
  end
endmodule

// File: rtl/slip_frame_buffer.sv
`timescale 1ns/1ps
module slip_frame_buffer
  import slip_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CNT_W     = 8
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              wr_sof_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic              rd_sof_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              slip_under_o,
  output logic              slip_over_o,
  output logic [CNT_W-1:0]  under_cnt_o,
  output logic [CNT_W-1:0]  over_cnt_o
);
  localparam int unsigned POS_W  = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int unsigned ADDR_W = POS_W + 1;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;
  fidx_t             wr_gray, wr_gray_rs, rd_gray, rd_gray_ws;
  logic              drop_tgl, drop_tgl_rs;

  always_ff @(posedge wr_clk_i) begin
    if (we) mem_q[waddr] <= wr_data_i;
  end
  assign rdata = mem_q[raddr];

  slip_wr_ctrl #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) u_wr (
    .clk_i      (wr_clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (wr_valid_i),
    .sof_i      (wr_sof_i),
    .rd_gray_i  (rd_gray_ws),
    .wr_gray_o  (wr_gray),
    .we_o       (we),
    .waddr_o    (waddr),
    .drop_tgl_o (drop_tgl)
  );

  slip_sync #(.W(IDX_W)) u_sync_rd2wr (
    .clk_i (wr_clk_i), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rd_gray_ws)
  );
  slip_sync #(.W(IDX_W)) u_sync_wr2rd (
    .clk_i (rd_clk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wr_gray_rs)
  );
  slip_sync #(.W(1)) u_sync_drop (
    .clk_i (rd_clk_i), .rst_ni(rst_ni), .d_i(drop_tgl), .q_o(drop_tgl_rs)
  );

  slip_rd_ctrl #(
    .FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_rd (
    .clk_i       (rd_clk_i),
    .rst_ni      (rst_ni),
    .wr_gray_i   (wr_gray_rs),
    .drop_tgl_i  (drop_tgl_rs),
    .rdata_i     (rdata),
    .raddr_o     (raddr),
    .rd_gray_o   (rd_gray),
    .valid_o     (rd_valid_o),
    .sof_o       (rd_sof_o),
    .data_o      (rd_data_o),
    .under_o     (slip_under_o),
    .over_o      (slip_over_o),
    .under_cnt_o (under_cnt_o),
    .over_cnt_o  (over_cnt_o)
  );
endmodule

// File: rtl/slip_frame_buffer_chk.sv
`timescale 1ns/1ps
module slip_frame_buffer_chk #(
  parameter int unsigned FRAME_LEN = 8,
  parameter int unsigned CNT_W     = 8
) (
  input logic             rd_clk_i,
  input logic             rst_ni,
  input logic             rd_valid_o,
  input logic             rd_sof_o,
  input logic             slip_under_o,
  input logic             slip_over_o,
  input logic [CNT_W-1:0] under_cnt_o,
  input logic [CNT_W-1:0] over_cnt_o
);
  localparam int unsigned SW = $clog2(FRAME_LEN + 1) + 1;

  logic [SW-1:0] since_q;
  logic          seen_sof_q;

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q    <= '0;
      seen_sof_q <= 1'b0;
    end else if (rd_sof_o) begin
      since_q    <= SW'(1);
      seen_sof_q <= 1'b1;
    end else if (rd_valid_o && since_q < SW'(FRAME_LEN)) begin
      since_q <= since_q + SW'(1);
    end
  end

  a_r2_sof_needs_valid: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_sof_o |-> rd_valid_o);

  a_r2_valid_holds: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o |=> rd_valid_o);

  a_r2_sof_spacing: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_valid_o && seen_sof_q) |-> (rd_sof_o == (since_q == SW'(FRAME_LEN))));

  a_r4_under_on_sof: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    slip_under_o |-> rd_sof_o);

  a_r6_under_step: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    slip_under_o |-> under_cnt_o == $past(under_cnt_o) + CNT_W'(1));

  a_r6_under_hold: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !slip_under_o |-> $stable(under_cnt_o));

  a_r6_over_step: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    slip_over_o |-> over_cnt_o == $past(over_cnt_o) + CNT_W'(1));

  a_r6_over_hold: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !slip_over_o |-> $stable(over_cnt_o));
endmodule

bind slip_frame_buffer slip_frame_buffer_chk #(
  .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
  .rd_clk_i     (rd_clk_i),
  .rst_ni       (rst_ni),
  .rd_valid_o   (rd_valid_o),
  .rd_sof_o     (rd_sof_o),
  .slip_under_o (slip_under_o),
  .slip_over_o  (slip_over_o),
  .under_cnt_o  (under_cnt_o),
  .over_cnt_o   (over_cnt_o)
);

// File: tb/tb_slip_frame_buffer.sv
`timescale 1ns/1ps
module tb_slip_frame_buffer;
  localparam int L  = 8;
  localparam int DW = 16;
  localparam int CW = 8;

  typedef struct packed {
    int unsigned half_ps;
    int unsigned nfr;
    int unsigned gap;
    bit          need_over;
    bit          need_under;
  } scen_t;

  localparam scen_t SCN [4] = '{
    '{2000, 10, 0, 1'b0, 1'b0},
    '{3000, 10, 0, 1'b0, 1'b1},
    '{1400, 12, 0, 1'b1, 1'b0},
    '{2000, 10, 6, 1'b0, 1'b1}
  };

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_ni = 1'b0;
  logic wr_valid = 1'b0, wr_sof = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid_o, rd_sof_o, slip_under_o, slip_over_o;
  logic [DW-1:0] rd_data_o;
  logic [CW-1:0] under_cnt_o, over_cnt_o;
  real wr_half = 2.0;

  always #2 rd_clk = ~rd_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  slip_frame_buffer #(.FRAME_LEN(L), .DATA_W(DW), .CNT_W(CW)) dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_sof_i(wr_sof), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid_o), .rd_sof_o(rd_sof_o), .rd_data_o(rd_data_o),
    .slip_under_o(slip_under_o), .slip_over_o(slip_over_o),
    .under_cnt_o(under_cnt_o), .over_cnt_o(over_cnt_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // read-side monitor
  int nframes, distinct, m_under, m_over, bad_word, bad_seq, bad_uf, mpos;
  int cur_id, first_id;

  always @(negedge rd_clk) begin
    if (!rst_ni) begin
      nframes = 0; distinct = 0; m_under = 0; m_over = 0;
      bad_word = 0; bad_seq = 0; bad_uf = 0; mpos = 0;
      cur_id = -1; first_id = -1;
    end else begin
      if (slip_over_o) m_over++;
      if (slip_under_o && !rd_sof_o) bad_uf++;
      if (rd_valid_o) begin
        if (rd_sof_o) begin
          int id;
          id = int'(rd_data_o[15:8]);
          if (rd_data_o[7:0] != 8'd0) bad_word++;
          if (nframes == 0) begin
            first_id = id;
            distinct++;
            if (slip_under_o) bad_uf++;
          end else if (slip_under_o) begin
            m_under++;
            if (id != cur_id) bad_uf++;
          end else begin
            distinct++;
            if (id <= cur_id) bad_seq++;
          end
          if (mpos != L - 1 && nframes != 0) bad_word++;
          cur_id = id;
          mpos = 0;
          nframes++;
        end else if (nframes > 0) begin
          mpos++;
          if (mpos >= L || int'(rd_data_o[15:8]) != cur_id || int'(rd_data_o[7:0]) != mpos)
            bad_word++;
        end
      end else if (nframes > 0) begin
        bad_word++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_word(input bit sof, input int id, input int k);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_sof   = sof;
    wr_data  = {id[7:0], k[7:0]};
  endtask

  task automatic idle_wr(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b0;
      wr_sof   = 1'b0;
    end
  endtask

  task automatic write_frame(input int id, input int gap);
    for (int k = 0; k < L; k++) put_word(k == 0, id, k);
    idle_wr(gap + 1);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (4) @(negedge rd_clk);
    rst_ni = 1'b1;
    @(negedge rd_clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge rd_clk);
    chk(rd_valid_o == 1'b0, "R1", "valid in reset", int'(rd_valid_o), 0);
    chk(rd_sof_o == 1'b0 && slip_under_o == 1'b0 && slip_over_o == 1'b0,
        "R1", "markers in reset", int'({rd_sof_o, slip_under_o, slip_over_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge rd_clk);
    chk(under_cnt_o == '0 && over_cnt_o == '0, "R1", "counters after reset",
        int'(under_cnt_o) + int'(over_cnt_o), 0);

    // R7/R2: stray words, then a frame cut short by a new start
    for (int k = 0; k < 3; k++) put_word(1'b0, 8'hEE, k);
    for (int k = 0; k < L / 2; k++) put_word(k == 0, 8'h55, k);
    idle_wr(2);
    repeat (40) @(negedge rd_clk);
    chk(rd_valid_o == 1'b0, "R2", "idle before first full frame", int'(rd_valid_o), 0);
    for (int k = 0; k < 3; k++) put_word(k == 0, 8'h66, k);
    write_frame(1, 0);
    repeat (6 * L) @(negedge rd_clk);
    chk(rd_valid_o == 1'b1, "R2", "output started", int'(rd_valid_o), 1);
    chk(first_id == 1, "R7", "first delivered frame id", first_id, 1);
    chk(bad_word == 0, "R3", "frame integrity with aborted start", bad_word, 0);

    // R6/R4: only one frame present -> endless repeats, counter wraps
    repeat (270 * L) @(negedge rd_clk);
    chk(m_under > (1 << CW), "R4", "repeat pulses seen", m_under, (1 << CW) + 1);
    chk(int'(under_cnt_o) == (m_under % (1 << CW)), "R6", "under counter wrap",
        int'(under_cnt_o), m_under % (1 << CW));
    chk(bad_uf == 0, "R4", "repeat pulse placement", bad_uf, 0);

    // rate scenarios
    for (int s = 0; s < 4; s++) begin
      wr_half = real'(SCN[s].half_ps) / 1000.0;
      do_reset();
      for (int f = 0; f < int'(SCN[s].nfr); f++) write_frame(f, int'(SCN[s].gap));
      repeat (10 * L) @(negedge rd_clk);
      chk(bad_word == 0, "R3", $sformatf("scn%0d frame integrity", s), bad_word, 0);
      chk(bad_seq == 0, "R8", $sformatf("scn%0d order", s), bad_seq, 0);
      chk(bad_uf == 0, "R4", $sformatf("scn%0d repeat placement", s), bad_uf, 0);
      chk(first_id == 0, "R2", $sformatf("scn%0d first frame", s), first_id, 0);
      chk(int'(under_cnt_o) == m_under, "R6", $sformatf("scn%0d under count", s),
          int'(under_cnt_o), m_under);
      chk(int'(over_cnt_o) == m_over, "R6", $sformatf("scn%0d over count", s),
          int'(over_cnt_o), m_over);
      chk(distinct + int'(over_cnt_o) == int'(SCN[s].nfr), "R8",
          $sformatf("scn%0d delivered plus dropped", s),
          distinct + int'(over_cnt_o), int'(SCN[s].nfr));
      if (SCN[s].need_over)
        chk(over_cnt_o != '0, "R5", $sformatf("scn%0d fast writer drops", s),
            int'(over_cnt_o), 1);
      if (SCN[s].need_under)
        chk(under_cnt_o != '0, "R4", $sformatf("scn%0d slow writer repeats", s),
            int'(under_cnt_o), 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule